// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

This block is a memory-mapped controller for 32 general-purpose pins, organised as four identical sections of eight pins. Every section has its own 64-byte register window, and all windows share one layout. The layout holds a direction register, an output data register, a synchronised input view, a raw interrupt status, an interrupt mask with separate set and clear ports, a masked status view, and a per-pin interrupt type. The block sits on a simple single-cycle register bus. Writes take effect at the clock edge on which `bus_we` is high. Reads are combinational from the current address.

Each pin level passes through a two-flop synchroniser. A pin in edge mode latches its status bit on a rising edge of the synchronised level. A pin in level mode sets its status bit in every cycle that the synchronised level is high. All 32 masked status bits are ORed into one interrupt line, which is registered.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: After reset, every section reads direction 0xFF (all inputs), mask 0xFF, and output, status and type 0. `pin_oe`, `pin_out` and `irq` are all 0.
- R2: Section k occupies byte addresses k*0x40 to k*0x40+0x3F. Pin n is bit n&7 of section n>>3. A write to one section leaves the other sections unchanged.
- R3: Offset 0x10 is the direction register, which reads back what was written. A bit value of 1 means input. `pin_oe[n]` is the inverse of the direction bit of pin n.
- R4: Offset 0x14 is the output register. It reads back the written value and drives `pin_out` from the next cycle.
- R5: Offset 0x18 returns the pin levels two clock edges after they are applied. Writes to it have no effect.
- R6: Writing 1s to offset 0x08 sets those mask bits, and offset 0x08 reads the mask. Writing 1s to offset 0x0C clears mask bits, and offset 0x0C reads 0.
- R7: In edge mode (type bit 0), a rising edge of the synchronised pin sets the status bit at offset 0x04. A falling edge leaves the status bit unchanged.
- R8: Writing to offset 0x04 clears exactly the status bits written as 1.
- R9: Offset 0x00 reads status AND NOT mask. A masked pin still records status.
- R10: Writing 1s to offset 0x20 puts those pins in level mode, and offset 0x20 reads the type bits. In level mode, status cannot be cleared while the synchronised pin is high. Once the pin is low, a write to offset 0x04 clears the bit.
- R11: Read-data bits 31:8 are always 0. Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20 read 0, and writes to them are ignored.
- R12: `irq` is the registered OR of all masked status bits. It follows a status change one cycle later.
- R13: When a new edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address: bits 7:6 select the section, bits 5:0 the offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data values |
| pin_oe | output | 32 | Output enables, high means driven |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench raises a pin edge at the exact cycle a status-clearing write lands on the same bit. A design that let the clear win would lose that interrupt. It holds a level-mode pin high while writing the clear. A design that treated level pins like edge pins would read status 0 there. It checks that falling edges and zero-valued clear writes leave status set, and that a masked pin still shows raw status while neither the masked view nor `irq` reacts. It also checks that the unmask port and unmapped offsets read 0 and swallow writes, and that `irq` still shows the old value one cycle after a clear.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;

    localparam int SECT_PINS = 8;
    localparam int NUM_SECT  = 4;
    localparam int NUM_PINS  = SECT_PINS * NUM_SECT;
    localparam int OFF_W     = 6;
    localparam int SEL_W     = $clog2(NUM_SECT);
    localparam int ADDR_W    = OFF_W + SEL_W;
    localparam int DATA_W    = 32;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [3:0] {
        RG_MSTAT  = 4'd0,
        RG_STAT   = 4'd1,
        RG_MSET   = 4'd2,
        RG_MCLR   = 4'd3,
        RG_DIR    = 4'd4,
        RG_DOUT   = 4'd5,
        RG_DIN    = 4'd6,
        RG_TYPE   = 4'd7,
        RG_NONE   = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic [SECT_PINS-1:0] dir;
        logic [SECT_PINS-1:0] dout;
        logic [SECT_PINS-1:0] stat;
        logic [SECT_PINS-1:0] mask;
        logic [SECT_PINS-1:0] ltype;
    } sect_state_t;

    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
        case (off)
            6'h00:   return RG_MSTAT;
            6'h04:   return RG_STAT;
            6'h08:   return RG_MSET;
            6'h0C:   return RG_MCLR;
            6'h10:   return RG_DIR;
            6'h14:   return RG_DOUT;
            6'h18:   return RG_DIN;
            6'h20:   return RG_TYPE;
            default: return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d_async;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_section.sv
module gpio_section
    import gpio_sect_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [SECT_PINS-1:0] wdata,
    input  logic [SECT_PINS-1:0] lvl,
    output logic [SECT_PINS-1:0] rd_val,
    output logic [SECT_PINS-1:0] pend,
    output logic [SECT_PINS-1:0] dout,
    output logic [SECT_PINS-1:0] oe
);
    sect_state_t          st;
    logic [SECT_PINS-1:0] lvl_q;
    logic [SECT_PINS-1:0] hit;
    logic [SECT_PINS-1:0] clr;

    // edge pins fire on a rising sync level, level pins while high
    assign hit = (st.ltype & lvl) | (~st.ltype & lvl & ~lvl_q);
    assign clr = (wr_en && sel == RG_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.dir   <= '1;
            st.dout  <= '0;
            st.stat  <= '0;
            st.mask  <= '1;
            st.ltype <= '0;
            lvl_q    <= '0;
        end else begin
            lvl_q   <= lvl;
            st.stat <= (st.stat & ~clr) | hit;
            if (wr_en) begin
                case (sel)
                    RG_DIR:  st.dir   <= wdata;
                    RG_DOUT: st.dout  <= wdata;
                    RG_MSET: st.mask  <= st.mask | wdata;
                    RG_MCLR: st.mask  <= st.mask & ~wdata;
                    RG_TYPE: st.ltype <= st.ltype | wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            RG_MSTAT: rd_val = st.stat & ~st.mask;
            RG_STAT:  rd_val = st.stat;
            RG_MSET:  rd_val = st.mask;
            RG_DIR:   rd_val = st.dir;
            RG_DOUT:  rd_val = st.dout;
            RG_DIN:   rd_val = lvl;
            RG_TYPE:  rd_val = st.ltype;
            default:  rd_val = '0;
        endcase
    end

    assign pend = st.stat & ~st.mask;
    assign dout = st.dout;
    assign oe   = ~st.dir;
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
    import gpio_sect_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic              irq
);
    logic [NUM_PINS-1:0]  lvl;
    logic [SEL_W-1:0]     sect_idx;
    reg_sel_e             sel;
    logic [SECT_PINS-1:0] rd_arr [NUM_SECT];
    logic [NUM_PINS-1:0]  pend_all;
    logic                 irq_q;

    assign sect_idx = bus_addr[OFF_W +: SEL_W];
    assign sel      = decode_off(bus_addr[OFF_W-1:0]);

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (lvl)
    );

    for (genvar k = 0; k < NUM_SECT; k++) begin : g_sect
        gpio_section u_sect (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (bus_we && sect_idx == SEL_W'(k)),
            .sel    (sel),
            .wdata  (bus_wdata[SECT_PINS-1:0]),
            .lvl    (lvl[k*SECT_PINS +: SECT_PINS]),
            .rd_val (rd_arr[k]),
            .pend   (pend_all[k*SECT_PINS +: SECT_PINS]),
            .dout   (pin_out[k*SECT_PINS +: SECT_PINS]),
            .oe     (pin_oe[k*SECT_PINS +: SECT_PINS])
        );
    end

    assign bus_rdata = {{(DATA_W-SECT_PINS){1'b0}}, rd_arr[sect_idx]};

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend_all;
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio_sect_checker.sv
module gpio_sect_checker
    import gpio_sect_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq
);
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SECT_PINS] == '0);

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        decode_off(bus_addr[OFF_W-1:0]) == RG_NONE |-> bus_rdata == '0);

    p_unmask_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        bus_addr[OFF_W-1:0] == 6'h0C |-> bus_rdata == '0);

    p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr[OFF_W-1:0] == 6'h10 |=>
        ((pin_oe >> (SECT_PINS * $past(bus_addr[OFF_W +: SEL_W]))) & 32'hFF)
            == {24'h0, ~$past(bus_wdata[7:0])});

    p_out_follows_write_r4: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr[OFF_W-1:0] == 6'h14 |=>
        ((pin_out >> (SECT_PINS * $past(bus_addr[OFF_W +: SEL_W]))) & 32'hFF)
            == {24'h0, $past(bus_wdata[7:0])});

    p_irq_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq);
endmodule

bind gpio_sect_ctrl gpio_sect_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/test_gpio_sect_ctrl.sv
module test_gpio_sect_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_sect_ctrl i_gpio_sect_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {req number, write flag, address, write data or expected read data}
    localparam int NV = 20;
    localparam logic [44:0] VEC [NV] = '{
        {4'd1,  1'b0, 8'h10, 32'h0000_00FF},
        {4'd1,  1'b0, 8'h08, 32'h0000_00FF},
        {4'd1,  1'b0, 8'hD4, 32'h0000_0000},
        {4'd1,  1'b0, 8'h44, 32'h0000_0000},
        {4'd1,  1'b0, 8'hA0, 32'h0000_0000},
        {4'd3,  1'b1, 8'h50, 32'h0000_000F},
        {4'd3,  1'b0, 8'h50, 32'h0000_000F},
        {4'd2,  1'b0, 8'h10, 32'h0000_00FF},
        {4'd4,  1'b1, 8'h54, 32'hFFFF_FFA5},
        {4'd11, 1'b0, 8'h54, 32'h0000_00A5},
        {4'd5,  1'b1, 8'h18, 32'h0000_00FF},
        {4'd5,  1'b0, 8'h18, 32'h0000_0000},
        {4'd6,  1'b1, 8'h0C, 32'h0000_000F},
        {4'd6,  1'b0, 8'h08, 32'h0000_00F0},
        {4'd6,  1'b0, 8'h0C, 32'h0000_0000},
        {4'd6,  1'b1, 8'h08, 32'h0000_0001},
        {4'd6,  1'b0, 8'h08, 32'h0000_00F1},
        {4'd11, 1'b1, 8'h24, 32'h0000_0033},
        {4'd11, 1'b0, 8'h24, 32'h0000_0000},
        {4'd11, 1'b0, 8'h3C, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[v][44:41], v);
            if (VEC[v][40]) wr(VEC[v][39:32], VEC[v][31:0]);
            else            rd(tag, VEC[v][39:32], VEC[v][31:0]);
        end
        chk("R3 R2 pin_oe map", pin_oe, 32'h0000_F000);
        chk("R4 R2 pin_out map", pin_out, 32'h0000_A500);

        // R7/R12: edge on pin 17 (section 2 bit 1), unmasked
        wr(8'h8C, 32'h02);
        @(negedge clk); pin_in[17] = 1'b1;
        wait_n(5);
        rd("R5 input level", 8'h98, 32'h02);
        rd("R7 rising edge", 8'h84, 32'h02);
        rd("R9 masked view", 8'h80, 32'h02);
        chk("R12 irq set", {31'h0, irq}, 32'h1);
        pin_in[17] = 1'b0;
        wait_n(5);
        rd("R7 falling keeps", 8'h84, 32'h02);
        wr(8'h84, 32'h00);
        rd("R8 zero write keeps", 8'h84, 32'h02);
        wr(8'h84, 32'h02);
        rd("R8 cleared", 8'h84, 32'h00);
        chk("R12 irq one cycle late", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R12 irq dropped", {31'h0, irq}, 32'h0);

        // R9: masked pin 18 records status but no irq
        pin_in[18] = 1'b1;
        wait_n(5);
        rd("R9 raw status", 8'h84, 32'h04);
        rd("R9 masked hidden", 8'h80, 32'h00);
        chk("R9 no irq", {31'h0, irq}, 32'h0);
        rd("R9 read-only", 8'h80, 32'h00);

        // R10: level mode on pin 18
        wr(8'hA0, 32'h04);
        rd("R10 type read", 8'hA0, 32'h04);
        wr(8'h84, 32'h04);
        rd("R10 held while high", 8'h84, 32'h04);
        pin_in[18] = 1'b0;
        wait_n(4);
        wr(8'h84, 32'h04);
        rd("R10 clears when low", 8'h84, 32'h00);

        // R13: edge on pin 24 coincides with clearing write
        @(negedge clk); pin_in[24] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'hC4; bus_wdata = 32'h01; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd("R13 edge beats clear", 8'hC4, 32'h01);
        wr(8'hC4, 32'h01);
        rd("R13 later clear", 8'hC4, 32'h00);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule